// File: doc/BRIEF.md
# Bulk Register Write/Read Packet Formatter

This block turns one bulk register access request into the stream of 32-bit words that a transmit FIFO expects. A request names the operation (write or read), a 4-bit target device number, a full 32-bit start address and a byte count. For a write, the data bytes follow on a separate byte-wide stream. The block builds a six-byte header and computes an 8-bit CRC over it. For a write it pairs the data bytes into words and appends a second CRC that covers the data alone. Every word carries start and end markers and a rolling packet number.

Each CRC always sits in the low byte of a word of its own, so the formatter inserts zero pad bytes wherever needed. While a packet is in flight, the request input is held off. It is accepted again only after the last word of the packet has left through the output handshake. A request with a byte count of zero or above the packet limit is consumed and rejected with a one-cycle error pulse. Nothing is emitted for it.

Top module: `bulk_pkt_fmt`

## Requirements
- R1: Payload occupies only bits 15..0 of an output word; the earlier byte of a pair is in bits 7..0 and the later in bits 15..8; bits 29..20 are always zero.
- R2: Bit 31 is set on the first word of a packet only and bit 30 on the last word only.
- R3: Bits 19..16 hold the packet number, 0 after reset, incremented by one (modulo 16) after each packet whose last word is accepted; rejected requests do not advance it.
- R4: The header occupies the first three words, in this byte order: byte0 = {c[8], 2'b00, op, dev[3:0]} with op 1 for write and 0 for read, bytes 1..4 = address bits 31..24, 23..16, 15..8, 7..0, byte5 = c[7:0], where c = byte count minus one.
- R5: The fourth word carries the header CRC in bits 7..0 and zero in bits 15..8. The CRC is CRC-8 with polynomial 0x4D, initial value 0xFF, MSB-first and no final XOR, taken over the six header bytes.
- R6: In a write packet, the data bytes follow the header CRC word in arrival order, two to a word. With an odd count, the final data byte is in bits 7..0 with zero above it. A last word follows, holding the data CRC (same CRC-8, over the data bytes only) in bits 7..0 and zero in bits 15..8.
- R7: A read packet is exactly the four header words, with the end marker on the header CRC word, and consumes no data bytes.
- R8: A request with count 0 or count above 470 is accepted, raises cmd_err for exactly one cycle, emits no word and leaves the packet number unchanged.
- R9: out_word is held stable while out_valid is high and out_ready low. cmd_ready stays low from an accepted request until the last word of its packet has been accepted.
- R10: After reset, out_valid, din_ready and cmd_err are low and cmd_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Request accepted when high with cmd_valid |
| cmd_write | input | 1 | 1 = write packet, 0 = read packet |
| cmd_dev | input | 4 | Target device number |
| cmd_addr | input | 32 | Start register address |
| cmd_count | input | 10 | Byte count, valid range 1..470 |
| cmd_err | output | 1 | One-cycle pulse for a rejected request |
| din_valid | input | 1 | Write data byte present |
| din_ready | output | 1 | Write data byte taken when high with din_valid |
| din_byte | input | 8 | Write data byte |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the word |
| out_word | output | 32 | Formatted word: start, end, packet number, two payload bytes |

## Verification
The assertions assume that out_ready is the only thing able to stall the output. They also assume that din_valid bytes belong to the packet currently in flight. For that reason the stimulus offers data bytes only after a write request has been accepted, and never more bytes than that request's count. The stimulus holds request fields stable from the moment cmd_valid rises until cmd_ready answers. For read packets din_valid stays high throughout, to show that no bytes are taken. The sweep covers every write count from 1 to 24, the counts at the ninth-bit boundary and the 470 limit, and rejected counts. It runs with free-flowing output and with pseudo-random backpressure on out_ready.

// File: rtl/bulk_pkt_pkg.sv
package bulk_pkt_pkg;

  localparam int ADDR_W   = 32;
  localparam int DEV_W    = 4;
  localparam int ID_W     = 4;
  localparam int HDR_B    = 6;
  localparam logic [7:0] CRC_POLY = 8'h4D;
  localparam logic [7:0] CRC_INIT = 8'hFF;
  localparam logic [7:0] PAD_BYTE = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_HCRC,
    ST_DATA,
    ST_DCRC,
    ST_FIN
  } fmt_state_e;

  // One byte through the CRC-8, MSB first.
  function automatic logic [7:0] crc8_step(input logic [7:0] c_in,
                                           input logic [7:0] b);
    logic [7:0] c;
    c = c_in ^ b;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ((c << 1) ^ CRC_POLY) : (c << 1);
    end
    return c;
  endfunction

  // Output word layout: start, end, packet number, high byte, low byte.
  function automatic logic [31:0] pack_word(input logic sop,
                                            input logic eop,
                                            input logic [ID_W-1:0] id,
                                            input logic [7:0] hi,
                                            input logic [7:0] lo);
    logic [31:0] w;
    w        = '0;
    w[31]    = sop;
    w[30]    = eop;
    w[19:16] = id;
    w[15:8]  = hi;
    w[7:0]   = lo;
    return w;
  endfunction

endpackage

// File: rtl/bulk_pkt_hdr.sv
module bulk_pkt_hdr
  import bulk_pkt_pkg::*;
(
  input  logic                 is_write,
  input  logic [DEV_W-1:0]     dev,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [8:0]           cnt_m1,
  output logic [HDR_B*8-1:0]   hdr_bytes,
  output logic [7:0]           hdr_crc
);

  always_comb begin
    hdr_bytes            = '0;
    hdr_bytes[7:0]       = {cnt_m1[8], 2'b00, is_write, dev};
    hdr_bytes[15:8]      = addr[31:24];
    hdr_bytes[23:16]     = addr[23:16];
    hdr_bytes[31:24]     = addr[15:8];
    hdr_bytes[39:32]     = addr[7:0];
    hdr_bytes[47:40]     = cnt_m1[7:0];
  end

  always_comb begin
    logic [7:0] c;
    c = CRC_INIT;
    for (int i = 0; i < HDR_B; i++) begin
      c = crc8_step(c, hdr_bytes[8*i +: 8]);
    end
    hdr_crc = c;
  end

endmodule

// File: rtl/bulk_pkt_crc.sv
module bulk_pkt_crc
  import bulk_pkt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc <= CRC_INIT;
    else if (clr)    crc <= CRC_INIT;
    else if (en)     crc <= crc8_step(crc, din);
  end

endmodule

// File: rtl/bulk_pkt_outreg.sv
module bulk_pkt_outreg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] word_in,
  input  logic        ready,
  output logic        valid,
  output logic [31:0] word,
  output logic        can_load
);

  assign can_load = !valid || ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      word  <= '0;
    end else if (load && can_load) begin
      valid <= 1'b1;
      word  <= word_in;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/bulk_pkt_fmt.sv
module bulk_pkt_fmt
  import bulk_pkt_pkg::*;
#(
  parameter int MAX_BYTES = 470,
  parameter int CNT_W     = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic                 cmd_write,
  input  logic [DEV_W-1:0]     cmd_dev,
  input  logic [ADDR_W-1:0]    cmd_addr,
  input  logic [CNT_W-1:0]     cmd_count,
  output logic                 cmd_err,
  input  logic                 din_valid,
  output logic                 din_ready,
  input  logic [7:0]           din_byte,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [31:0]          out_word
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_BYTES);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  fmt_state_e            state;
  logic                  r_write;
  logic [DEV_W-1:0]      r_dev;
  logic [ADDR_W-1:0]     r_addr;
  logic [8:0]            r_cm1;
  logic [1:0]            hidx;
  logic [CNT_W-1:0]      remain;
  logic                  have_lo;
  logic [7:0]            lo_byte;
  logic [ID_W-1:0]       pkt_id;
  logic                  err_q;

  logic [HDR_B*8-1:0]    hdr_bytes;
  logic [7:0]            hdr_crc;
  logic [7:0]            dat_crc;
  logic                  can_load;
  logic                  load;
  logic [31:0]           nxt_word;

  // Named events for the checker
  logic                  cmd_fire;
  logic                  cnt_ok;
  logic                  din_fire;
  logic                  last_byte;
  logic                  eop_fire;
  logic                  sop_fire;

  assign cmd_ready = (state == ST_IDLE);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign cnt_ok    = (cmd_count != '0) && (cmd_count <= LIMIT);
  assign din_ready = (state == ST_DATA) && can_load;
  assign din_fire  = din_valid && din_ready;
  assign last_byte = din_fire && (remain == ONE);
  assign eop_fire  = out_valid && out_ready && out_word[30];
  assign sop_fire  = out_valid && out_ready && out_word[31];
  assign cmd_err   = err_q;

  bulk_pkt_hdr u_hdr (
    .is_write  (r_write),
    .dev       (r_dev),
    .addr      (r_addr),
    .cnt_m1    (r_cm1),
    .hdr_bytes (hdr_bytes),
    .hdr_crc   (hdr_crc)
  );

  bulk_pkt_crc u_dcrc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cmd_fire),
    .en    (din_fire),
    .din   (din_byte),
    .crc   (dat_crc)
  );

  bulk_pkt_outreg u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .word_in  (nxt_word),
    .ready    (out_ready),
    .valid    (out_valid),
    .word     (out_word),
    .can_load (can_load)
  );

  // Word selection
  always_comb begin
    logic [7:0] hb_lo;
    logic [7:0] hb_hi;
    case (hidx)
      2'd0:    begin hb_lo = hdr_bytes[7:0];   hb_hi = hdr_bytes[15:8];  end
      2'd1:    begin hb_lo = hdr_bytes[23:16]; hb_hi = hdr_bytes[31:24]; end
      default: begin hb_lo = hdr_bytes[39:32]; hb_hi = hdr_bytes[47:40]; end
    endcase
    load     = 1'b0;
    nxt_word = '0;
    unique case (state)
      ST_HDR: begin
        load     = can_load;
        nxt_word = pack_word(hidx == 2'd0, 1'b0, pkt_id, hb_hi, hb_lo);
      end
      ST_HCRC: begin
        load     = can_load;
        nxt_word = pack_word(1'b0, !r_write, pkt_id, PAD_BYTE, hdr_crc);
      end
      ST_DATA: begin
        if (din_fire && have_lo) begin
          load     = 1'b1;
          nxt_word = pack_word(1'b0, 1'b0, pkt_id, din_byte, lo_byte);
        end else if (last_byte) begin
          load     = 1'b1;
          nxt_word = pack_word(1'b0, 1'b0, pkt_id, PAD_BYTE, din_byte);
        end
      end
      ST_DCRC: begin
        load     = can_load;
        nxt_word = pack_word(1'b0, 1'b1, pkt_id, PAD_BYTE, dat_crc);
      end
      default: begin
        load     = 1'b0;
        nxt_word = '0;
      end
    endcase
  end

  // Sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      r_write <= 1'b0;
      r_dev   <= '0;
      r_addr  <= '0;
      r_cm1   <= '0;
      hidx    <= '0;
      remain  <= '0;
      have_lo <= 1'b0;
      lo_byte <= '0;
      pkt_id  <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cmd_fire) begin
            if (cnt_ok) begin
              state   <= ST_HDR;
              r_write <= cmd_write;
              r_dev   <= cmd_dev;
              r_addr  <= cmd_addr;
              r_cm1   <= 9'(cmd_count - ONE);
              hidx    <= '0;
              remain  <= cmd_count;
              have_lo <= 1'b0;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_HDR: begin
          if (can_load) begin
            hidx <= hidx + 2'd1;
            if (hidx == 2'd2) state <= ST_HCRC;
          end
        end
        ST_HCRC: begin
          if (can_load) state <= r_write ? ST_DATA : ST_FIN;
        end
        ST_DATA: begin
          if (din_fire) begin
            remain <= remain - ONE;
            if (!have_lo && (remain != ONE)) begin
              lo_byte <= din_byte;
              have_lo <= 1'b1;
            end else begin
              have_lo <= 1'b0;
            end
            if (remain == ONE) state <= ST_DCRC;
          end
        end
        ST_DCRC: begin
          if (can_load) state <= ST_FIN;
        end
        ST_FIN: begin
          if (eop_fire) begin
            pkt_id <= pkt_id + ID_W'(1);
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bulk_pkt_fmt_chk.sv
module bulk_pkt_fmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_ready,
  input logic        cmd_err,
  input logic        din_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_word,
  input logic [3:0]  pkt_id,
  input logic        eop_fire
);

  // R1: unused field stays zero
  a_r1_zero_field: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_word[29:20] == 10'd0));

  // R2: no word is both first and last
  a_r2_sop_eop_excl: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_word[31] && out_word[30]));

  // R3: packet number steps after a packet ends
  a_r3_id_step: assert property (@(posedge clk) disable iff (!rst_n)
    eop_fire |=> (pkt_id == $past(pkt_id) + 4'd1));

  // R3: packet number otherwise holds
  a_r3_id_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !eop_fire |=> $stable(pkt_id));

  // R3: emitted word carries the current packet number
  a_r3_id_field: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_word[19:16] == pkt_id));

  // R6: last word has a zero pad above its CRC
  a_r6_crc_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_word[30]) |-> (out_word[15:8] == 8'h00));

  // R8: a rejection leaves the output idle
  a_r8_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> (cmd_ready && !out_valid));

  // R8: the error pulse lasts one cycle
  a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> !cmd_err);

  // R9: word held under backpressure
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  // R9: no new request while a packet is in flight
  a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || din_ready) |-> !cmd_ready);

endmodule

bind bulk_pkt_fmt bulk_pkt_fmt_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .cmd_err   (cmd_err),
  .din_ready (din_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word  (out_word),
  .pkt_id    (pkt_id),
  .eop_fire  (eop_fire)
);

// File: tb/bulk_pkt_fmt_tb.sv
module bulk_pkt_fmt_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_write = 1'b0;
  logic [3:0]  cmd_dev = '0;
  logic [31:0] cmd_addr = '0;
  logic [9:0]  cmd_count = '0;
  logic        cmd_err;
  logic        din_valid = 1'b0;
  logic        din_ready;
  logic [7:0]  din_byte = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_word;

  int total = 0;
  int bad = 0;
  int cyc_all = 0;
  logic [3:0]  idc = '0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0]  eb [0:511];

  always #5 clk = ~clk;

  bulk_pkt_fmt u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_dev(cmd_dev), .cmd_addr(cmd_addr), .cmd_count(cmd_count),
    .cmd_err(cmd_err),
    .din_valid(din_valid), .din_ready(din_ready), .din_byte(din_byte),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Bit-serial CRC-8, poly 0x4D, MSB first
  function automatic logic [7:0] crc_bits(input logic [7:0] c_in, input logic [7:0] b);
    logic [7:0] c;
    logic fb;
    c = c_in;
    for (int k = 7; k >= 0; k--) begin
      fb = c[7] ^ b[k];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h4D;
    end
    return c;
  endfunction

  function automatic logic [7:0] dat(input int p, input int k);
    return 8'((k * 29 + p * 7 + 3) % 256);
  endfunction

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic offer_cmd(input bit w, input logic [3:0] dev,
                           input logic [31:0] addr, input int cnt);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = w; cmd_dev = dev;
    cmd_addr = addr; cmd_count = 10'(cnt);
    out_ready = 1'b1; din_valid = 1'b0;
    #1;
    while (!cmd_ready) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic run_pkt(input int p, input bit w, input int cnt, input bit bp);
    int nb, nw, got, bi, cyc;
    logic [7:0] c, cm1lo;
    logic [3:0] dev;
    logic [31:0] addr, expw, held;
    bit done, hold, busy_bad, hold_bad, word_bad;
    logic [9:0] cm1;
    dev  = 4'(p % 16);
    addr = 32'h1234_5678 ^ (32'(p) * 32'h0101_0101);
    cm1  = 10'(cnt - 1);
    cm1lo = cm1[7:0];
    eb[0] = {cm1[8], 2'b00, w, dev};
    eb[1] = addr[31:24]; eb[2] = addr[23:16];
    eb[3] = addr[15:8];  eb[4] = addr[7:0];
    eb[5] = cm1lo;
    c = 8'hFF;
    for (int i = 0; i < 6; i++) c = crc_bits(c, eb[i]);
    eb[6] = c; eb[7] = 8'h00;
    nb = 8;
    if (w) begin
      c = 8'hFF;
      for (int i = 0; i < cnt; i++) begin
        eb[nb] = dat(p, i); nb++;
        c = crc_bits(c, dat(p, i));
      end
      if (nb % 2 == 1) begin eb[nb] = 8'h00; nb++; end
      eb[nb] = c; eb[nb+1] = 8'h00; nb += 2;
    end
    nw = nb / 2;
    offer_cmd(w, dev, addr, cnt);
    got = 0; bi = 0; cyc = 0; done = 0; hold = 0;
    busy_bad = 0; hold_bad = 0; word_bad = 0; held = '0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      step_lfsr();
      out_ready = bp ? lfsr[0] : 1'b1;
      din_valid = !w || (bi < cnt);
      din_byte  = dat(p, bi);
      #1;
      cyc++;
      if (hold && (!out_valid || out_word != held)) hold_bad = 1;
      if (cmd_ready) busy_bad = 1;
      if (din_valid && din_ready) bi++;
      if (out_valid && out_ready) begin
        expw = {got == 0, got == nw - 1, 10'd0, idc, eb[2*got+1], eb[2*got]};
        if (!word_bad && got < nw) begin
          // R1 R2 R3 R4 R5 R6 R7: word content
          check(out_word == expw, "R4/R5/R6", $sformatf("pkt %0d word %0d", p, got),
                out_word, expw);
          if (out_word != expw) word_bad = 1;
        end
        got++;
        if (out_word[30]) done = 1;
      end
      hold = out_valid && !out_ready;
      held = out_word;
    end
    check(got == nw, w ? "R6" : "R7", $sformatf("pkt %0d word count", p), 32'(got), 32'(nw));
    check(bi == (w ? cnt : 0), w ? "R6" : "R7", $sformatf("pkt %0d bytes taken", p),
          32'(bi), 32'(w ? cnt : 0));
    check(!busy_bad && !hold_bad, "R9", $sformatf("pkt %0d handshake", p),
          {30'd0, busy_bad, hold_bad}, 32'd0);
    idc = idc + 4'd1;
    din_valid = 1'b0;
  endtask

  task automatic run_reject(input int cnt);
    bit quiet;
    offer_cmd(1'b1, 4'd3, 32'hDEAD_BEEF, cnt);
    @(negedge clk);
    cmd_valid = 1'b0;
    #1;
    // R8: error pulse one cycle after acceptance
    check(cmd_err == 1'b1, "R8", $sformatf("err pulse count %0d", cnt), 32'(cmd_err), 32'd1);
    quiet = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1;
      if (cmd_err || out_valid || !cmd_ready) quiet = 0;
    end
    check(quiet, "R8", $sformatf("quiet after reject %0d", cnt), 32'(quiet), 32'd1);
  endtask

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 150000) begin
      total++; bad++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R10: reset state
    check(!out_valid && !din_ready && !cmd_err && cmd_ready, "R10", "reset outputs",
          {28'd0, out_valid, din_ready, cmd_err, cmd_ready}, 32'h1);
    p = 0;
    for (int n = 1; n <= 24; n++) begin
      run_pkt(p, 1'b1, n, n % 2 == 0); p++;
    end
    foreach (eb[i]) ;
    run_reject(0);
    run_pkt(p, 1'b0, 1, 1'b0); p++;     // R3: id unchanged by reject
    run_reject(471);
    run_pkt(p, 1'b0, 256, 1'b1); p++;   // R4: ninth bit clear
    run_pkt(p, 1'b0, 257, 1'b0); p++;   // R4: ninth bit set
    run_reject(1023);
    run_pkt(p, 1'b1, 255, 1'b1); p++;
    run_pkt(p, 1'b1, 256, 1'b0); p++;
    run_pkt(p, 1'b1, 257, 1'b1); p++;
    run_pkt(p, 1'b1, 469, 1'b0); p++;
    run_pkt(p, 1'b1, 470, 1'b1); p++;
    run_pkt(p, 1'b0, 470, 1'b1); p++;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule